// File: doc/BRIEF.md
# Matrix Element Index Remapper

This block replaces the plain linear element counter of a vector operation with a matrix-multiply schedule. It is loaded with three matrix dimensions and a direction bit, then started with a single pulse. Each accepted step emits three register-element offsets: one into the left operand matrix (M rows by K columns), one into the right operand matrix (K rows by N columns), and one into the accumulator/result matrix (M rows by N columns). Feeding these offsets to any multiply-accumulate unit computes a full in-register matrix product. The unit can be integer, Galois-field, bitwise AND/OR or complex. The schedule does not depend on the operation.

The traversal comes from three chained wrap-around counters with no branching. The result row is the outer loop, the result column the middle loop, and the inner dimension the innermost loop. Any size from 1 to 8 is accepted in each dimension, including sizes that are not powers of two, with no padding. A reverse setting walks the same set of steps in exactly the opposite order. A registered valid/ready handshake paces the stream, the final step is flagged, and a one-cycle completion pulse follows it.

Top module: `mtx_remap`

## Requirements
- R1: After reset, `out_valid`, `done`, `out_last` and all three index outputs are 0.
- R2: Each dimension field holds its size minus one (3 bits, sizes 1 to 8). A `start` pulse while `out_valid` is low latches the fields and the `cfg_reverse` bit. The first step appears with `out_valid` high on the following cycle.
- R3: For step (i,j,k), the outputs are `idx_a` = i*K+k, `idx_b` = k*N+j and `idx_dst` = i*N+j, where M, N and K are the row, column and inner sizes.
- R4: With `cfg_reverse` = 0, k advances fastest, then j, then i, each counting up from 0. Exactly M*N*K steps are emitted for any sizes in range.
- R5: With `cfg_reverse` = 1, the emitted steps are the forward sequence in exactly reversed order. The first step is (M-1, N-1, K-1) and the last is (0,0,0).
- R6: A step is accepted only on a cycle with `out_valid` and `out_ready` both high. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R7: `out_last` is high exactly while the final step of the schedule is presented.
- R8: The cycle after the final step is accepted, `done` is high for exactly one cycle and `out_valid` is low. A later `start` replays the schedule from its first step.
- R9: `start` and changes on the configuration inputs while `out_valid` is high have no effect on the schedule. This includes a `start` in the same cycle the final step is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rows | input | 3 | Result rows minus one (M-1) |
| cfg_cols | input | 3 | Result columns minus one (N-1) |
| cfg_inner | input | 3 | Inner dimension minus one (K-1) |
| cfg_reverse | input | 1 | 1 runs the schedule in descending order |
| start | input | 1 | Begin a schedule when idle |
| out_ready | input | 1 | Consumer accepts the current step |
| out_valid | output | 1 | A step is presented |
| idx_a | output | 6 | Offset into the left operand matrix |
| idx_b | output | 6 | Offset into the right operand matrix |
| idx_dst | output | 6 | Offset into the accumulator/result matrix |
| out_last | output | 1 | Current step is the final one |
| done | output | 1 | One-cycle pulse after the final step is accepted |

## Verification
Two functions can fall in one cycle: accepting the final step, and a new `start` request. In that cycle the block is still busy, so the request must be dropped, and the counters must reload to their starting values at the same time. The bench provokes this by raising `start` with different configuration values exactly when the final step is handshaken, in reverse mode. It then checks that `done` pulses once and that `out_valid` stays low for the following two cycles. A separate run raises `start` in the middle of a schedule and checks that every later step still matches the originally latched sizes.

// File: rtl/mtx_remap_pkg.sv
package mtx_remap_pkg;

  localparam int DIM_W = 3;
  localparam int IDX_W = 2 * DIM_W;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } walk_dir_e;

endpackage

// File: rtl/mtx_loop_ctr.sv
module mtx_loop_ctr
  import mtx_remap_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  walk_dir_e    dir,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         at_end,
  output logic         end_nxt
);

  logic [W-1:0] first_val;
  logic [W-1:0] final_val;

  always_comb begin
    first_val = (dir == DIR_DOWN) ? lim : '0;
    final_val = (dir == DIR_DOWN) ? '0 : lim;
    at_end    = (cnt == final_val);
    if (load) begin
      cnt_nxt = first_val;
    end else if (step) begin
      if (at_end)                cnt_nxt = first_val;
      else if (dir == DIR_DOWN)  cnt_nxt = cnt - 1'b1;
      else                       cnt_nxt = cnt + 1'b1;
    end else begin
      cnt_nxt = cnt;
    end
    end_nxt = (cnt_nxt == final_val);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  // counting up advances by one unless wrapping
  assert_ctr_up_R4: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !at_end && dir == DIR_UP) |=> cnt == W'($past(cnt) + 1'b1));

  // counting down retreats by one unless wrapping
  assert_ctr_down_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !at_end && dir == DIR_DOWN) |=> cnt == W'($past(cnt) - 1'b1));

  // a held counter does not move
  assert_ctr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(cnt));

endmodule

// File: rtl/mtx_idx_calc.sv
module mtx_idx_calc #(
  parameter int DIM_W = 3,
  parameter int IDX_W = 6
) (
  input  logic [DIM_W-1:0] row_i,
  input  logic [DIM_W-1:0] col_j,
  input  logic [DIM_W-1:0] inr_k,
  input  logic [DIM_W-1:0] cols_lim,
  input  logic [DIM_W-1:0] inner_lim,
  output logic [IDX_W-1:0] off_a,
  output logic [IDX_W-1:0] off_b,
  output logic [IDX_W-1:0] off_d
);

  localparam int PW = IDX_W + 1;

  logic [PW-1:0] n_sz, k_sz, i_x, j_x, k_x;
  logic [PW-1:0] a_w, b_w, d_w;

  always_comb begin
    n_sz = PW'(cols_lim) + PW'(1);
    k_sz = PW'(inner_lim) + PW'(1);
    i_x  = PW'(row_i);
    j_x  = PW'(col_j);
    k_x  = PW'(inr_k);
    a_w  = PW'(i_x * k_sz) + k_x;
    b_w  = PW'(k_x * n_sz) + j_x;
    d_w  = PW'(i_x * n_sz) + j_x;
    off_a = a_w[IDX_W-1:0];
    off_b = b_w[IDX_W-1:0];
    off_d = d_w[IDX_W-1:0];
  end

endmodule

// File: rtl/mtx_remap.sv
module mtx_remap
  import mtx_remap_pkg::*;
#(
  parameter int DW = mtx_remap_pkg::DIM_W,
  parameter int IW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg_rows,
  input  logic [DW-1:0] cfg_cols,
  input  logic [DW-1:0] cfg_inner,
  input  logic          cfg_reverse,
  input  logic          start,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [IW-1:0] idx_a,
  output logic [IW-1:0] idx_b,
  output logic [IW-1:0] idx_dst,
  output logic          out_last,
  output logic          done
);

  localparam int NLOOP = 3;
  localparam int LP_I  = 0;
  localparam int LP_J  = 1;
  localparam int LP_K  = 2;
  localparam int ELW   = 2 * IW + 1;

  // latched configuration
  logic [DW-1:0] rows_q, cols_q, inner_q;
  walk_dir_e     dir_q;

  logic valid_q, last_q, done_q;
  logic [IW-1:0] a_q, b_q, d_q;

  logic start_acc, adv, fin, ld;
  walk_dir_e     dir_sel;
  logic [DW-1:0] lim_sel [NLOOP];
  logic          stp     [NLOOP];
  logic [DW-1:0] cnt     [NLOOP];
  logic [DW-1:0] cnt_nxt [NLOOP];
  logic          at_end  [NLOOP];
  logic          end_nxt [NLOOP];

  logic [IW-1:0] a_nxt, b_nxt, d_nxt;

  assign start_acc = start && !valid_q;
  assign adv       = valid_q && out_ready;
  assign fin       = adv && last_q;
  assign ld        = start_acc || fin;

  assign dir_sel        = start_acc ? walk_dir_e'(cfg_reverse) : dir_q;
  assign lim_sel[LP_I]  = start_acc ? cfg_rows  : rows_q;
  assign lim_sel[LP_J]  = start_acc ? cfg_cols  : cols_q;
  assign lim_sel[LP_K]  = start_acc ? cfg_inner : inner_q;

  // carry chain: innermost loop steps on every accepted element
  assign stp[LP_K] = adv;
  assign stp[LP_J] = adv && at_end[LP_K];
  assign stp[LP_I] = adv && at_end[LP_K] && at_end[LP_J];

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    mtx_loop_ctr #(.W(DW)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .load    (ld),
      .step    (stp[g]),
      .dir     (dir_sel),
      .lim     (lim_sel[g]),
      .cnt     (cnt[g]),
      .cnt_nxt (cnt_nxt[g]),
      .at_end  (at_end[g]),
      .end_nxt (end_nxt[g])
    );
  end

  mtx_idx_calc #(.DIM_W(DW), .IDX_W(IW)) u_calc (
    .row_i     (cnt_nxt[LP_I]),
    .col_j     (cnt_nxt[LP_J]),
    .inr_k     (cnt_nxt[LP_K]),
    .cols_lim  (lim_sel[LP_J]),
    .inner_lim (lim_sel[LP_K]),
    .off_a     (a_nxt),
    .off_b     (b_nxt),
    .off_d     (d_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rows_q  <= '0;
      cols_q  <= '0;
      inner_q <= '0;
      dir_q   <= DIR_UP;
    end else if (start_acc) begin
      rows_q  <= cfg_rows;
      cols_q  <= cfg_cols;
      inner_q <= cfg_inner;
      dir_q   <= walk_dir_e'(cfg_reverse);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      d_q     <= '0;
    end else begin
      done_q <= fin;
      if (start_acc)  valid_q <= 1'b1;
      else if (fin)   valid_q <= 1'b0;
      if (ld || adv) begin
        a_q    <= a_nxt;
        b_q    <= b_nxt;
        d_q    <= d_nxt;
        last_q <= end_nxt[LP_I] && end_nxt[LP_J] && end_nxt[LP_K];
      end
    end
  end

  assign out_valid = valid_q;
  assign idx_a     = a_q;
  assign idx_b     = b_q;
  assign idx_dst   = d_q;
  assign out_last  = last_q && valid_q;
  assign done      = done_q;

  // ---------------- assertions ----------------
  logic [ELW-1:0] dst_span;
  assign dst_span = ELW'((ELW'(rows_q) + 1'b1) * (ELW'(cols_q) + 1'b1));

  assert_dst_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (ELW'(idx_dst) < dst_span));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(idx_a) && $stable(idx_b) && $stable(idx_dst) && $stable(out_last)));

  assert_rev_ends_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (out_last && dir_q == DIR_DOWN) |-> (idx_a == '0 && idx_b == '0 && idx_dst == '0));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (done && !out_valid));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && start) |=> ($stable(rows_q) && $stable(cols_q) && $stable(inner_q)));

endmodule

// File: tb/mtx_remap_bench.sv
module mtx_remap_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_rows = '0, cfg_cols = '0, cfg_inner = '0;
  logic cfg_reverse = 1'b0;
  logic start = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_last, done;
  logic [5:0] idx_a, idx_b, idx_dst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;  // 50 MHz

  mtx_remap u_mtx_remap (
    .clk(clk), .rst(rst),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_inner(cfg_inner),
    .cfg_reverse(cfg_reverse), .start(start), .out_ready(out_ready),
    .out_valid(out_valid), .idx_a(idx_a), .idx_b(idx_b), .idx_dst(idx_dst),
    .out_last(out_last), .done(done)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {reverse, stall, rows-1, cols-1, inner-1}
  localparam int NCASE = 7;
  localparam logic [10:0] CASES [NCASE] = '{
    {1'b0, 1'b0, 3'd4, 3'd6, 3'd2},   // 5x7, K=3
    {1'b1, 1'b0, 3'd2, 3'd3, 3'd3},   // 3x4, K=4 reversed
    {1'b0, 1'b1, 3'd1, 3'd5, 3'd4},   // 2x6, K=5 stalled
    {1'b0, 1'b0, 3'd0, 3'd0, 3'd0},   // 1x1x1
    {1'b0, 1'b1, 3'd7, 3'd7, 3'd7},   // largest
    {1'b1, 1'b1, 3'd2, 3'd4, 3'd1},   // reversed with stalls
    {1'b1, 1'b1, 3'd2, 3'd4, 3'd1}    // replay of previous
  };

  // runs one schedule; poke >= 0 raises start with other config at that element
  task automatic run_case(input logic [2:0] m1, input logic [2:0] n1, input logic [2:0] k1,
                          input logic rv, input logic st, input int poke);
    int mm, nn, kk, total, e, p, ii, jj, qq, ea, eb, ed;
    bit ok, el;
    mm = int'(m1) + 1; nn = int'(n1) + 1; kk = int'(k1) + 1;
    total = mm * nn * kk;
    cfg_rows = m1; cfg_cols = n1; cfg_inner = k1; cfg_reverse = rv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = 0;
    while (e < total) begin
      out_ready = st ? ((cyc % 3) != 1) : 1'b1;
      if (e == poke) begin
        out_ready = 1'b1;
        start = 1'b1;
        cfg_rows = ~m1; cfg_cols = ~n1; cfg_inner = ~k1; cfg_reverse = ~rv;
      end
      p  = rv ? (total - 1 - e) : e;
      qq = p % kk;
      jj = (p / kk) % nn;
      ii = p / (kk * nn);
      ea = ii * kk + qq;
      eb = qq * nn + jj;
      ed = ii * nn + jj;
      el = (e == total - 1);
      ok = out_valid && (int'(idx_a) == ea) && (int'(idx_b) == eb) &&
           (int'(idx_dst) == ed) && (out_last == el);
      // R3 R4 R5 R6 R7 R9: order, offsets, stall hold, last flag, busy start ignored
      chk(ok, rv ? "R5 R3 R7 R6 R9 reverse step" : "R4 R3 R7 R6 R9 forward step",
          (int'(idx_a) << 12) | (int'(idx_b) << 6) | int'(idx_dst),
          (ea << 12) | (eb << 6) | ed);
      if (out_ready) e = e + 1;
      @(negedge clk);
      start = 1'b0;
      cfg_rows = m1; cfg_cols = n1; cfg_inner = k1; cfg_reverse = rv;
    end
    out_ready = 1'b0;
    chk(done && !out_valid, "R8 done pulse after final step", {done, out_valid}, 2);
    @(negedge clk);
    chk(!done && !out_valid, "R8 R9 done single and no restart", {done, out_valid}, 0);
    @(negedge clk);
    chk(!out_valid, "R9 still idle after start during final handshake", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(!out_valid && !done && !out_last && idx_a == 0 && idx_b == 0 && idx_dst == 0,
        "R1 reset state", {out_valid, done, out_last, idx_a, idx_b, idx_dst}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1 idle without start", out_valid, 0);

    // R2: first step one cycle after start
    cfg_rows = 3'd1; cfg_cols = 3'd2; cfg_inner = 3'd1; cfg_reverse = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_valid && idx_a == 0 && idx_b == 0 && idx_dst == 0,
        "R2 first step after start", {out_valid, idx_dst}, 64);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    for (int c = 0; c < NCASE; c++) begin
      run_case(CASES[c][8:6], CASES[c][5:3], CASES[c][2:0], CASES[c][10], CASES[c][9], -1);
    end

    // R9: start mid-schedule with different config
    run_case(3'd1, 3'd2, 3'd1, 1'b0, 1'b0, 4);
    // R9 with R8: start coinciding with acceptance of the final step (3x3x3 reversed)
    run_case(3'd2, 3'd2, 3'd2, 1'b1, 1'b1, 26);
    // R8: replay after completion starts again from the first step
    run_case(3'd2, 3'd2, 3'd2, 1'b1, 1'b0, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule